// File: doc/BRIEF.md
# Bridge Upstream Request Gate

This block sits on the secondary side of a downstream bridge port and holds the port's command word. Three bits of that word can be written: one lets the port master the primary bus, one turns on the memory windows, and one turns on the I/O window. Three further bits (special cycles, memory write-and-invalidate, palette snooping) are present but tied to zero. All other bits of the word also read as zero.

Upstream requests (memory read/write, I/O read/write, message-signalled interrupt writes) pass through a valid/ready channel. When mastering is disabled, a request is still forwarded rather than dropped. Its address is replaced by the legacy location 0xC0000. A write has every byte enable cleared, and a read is answered with an Unsupported Request indication on the beat it is accepted. Completions moving from the primary side toward the secondary side go straight through, whatever the command word holds.

Downstream requests are matched combinationally against three inclusive base/limit windows: the regular memory window, the prefetchable memory window and the I/O window. Each window claims a request only when its enable bit is set and the window is not empty.

Top module: `bridge_req_gate`

## Requirements
- R1: Command bits 0 (I/O space), 1 (memory space) and 2 (bus master) are writable, reset to 0, and read back on `cfg_rdata` from the clock edge at which `cfg_we` is sampled high. A request presented before that edge sees the previous value.
- R2: Bits 3, 4 and 5 of the command word, and every bit above them, always read 0, whatever is written.
- R3: With bus master set, an upstream request leaves with its kind, address and byte enables unchanged, and `cpl_ur` stays low.
- R4: With bus master clear, an upstream write (kind 1 memory write, 3 I/O write, 4 interrupt message) leaves with address 0xC0000 and all byte enables 0. Its kind is kept.
- R5: With bus master clear, an upstream read (kind 0 memory read, 2 I/O read) leaves with address 0xC0000 and its byte enables kept. `cpl_ur` is high exactly on the beat the read is accepted (`us_valid` and `uo_ready` both high).
- R6: The upstream channel adds no latency. `uo_valid` follows `us_valid` and `us_ready` follows `uo_ready` in the same cycle.
- R7: Completions pass from primary to secondary unaltered (valid, ready and tag) regardless of the command word.
- R8: A downstream memory request (kinds 0, 1, 4) sets `ds_hit[1]` when it falls in the regular window and `ds_hit[2]` when it falls in the prefetchable window. Both bounds are inclusive. Both bits stay 0 while the memory space bit is clear.
- R9: A downstream I/O request (kinds 2, 3) sets `ds_hit[0]` when it falls within the inclusive I/O window, and only while the I/O space bit is set. A request of the other class never sets a bit of the wrong class.
- R10: A window whose limit is below its base claims nothing, even when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Command word write strobe |
| cfg_wdata | input | 16 | Command word write data |
| cfg_rdata | output | 16 | Command word read value |
| mem_base | input | ADDR_W | Regular memory window base |
| mem_limit | input | ADDR_W | Regular memory window limit |
| pmem_base | input | ADDR_W | Prefetchable window base |
| pmem_limit | input | ADDR_W | Prefetchable window limit |
| io_base | input | ADDR_W | I/O window base |
| io_limit | input | ADDR_W | I/O window limit |
| us_valid | input | 1 | Upstream request valid |
| us_ready | output | 1 | Upstream request ready |
| us_kind | input | 3 | Upstream request kind |
| us_addr | input | ADDR_W | Upstream request address |
| us_be | input | BE_W | Upstream byte enables |
| uo_valid | output | 1 | Forwarded request valid |
| uo_ready | input | 1 | Forwarded request ready |
| uo_kind | output | 3 | Forwarded request kind |
| uo_addr | output | ADDR_W | Forwarded request address |
| uo_be | output | BE_W | Forwarded byte enables |
| cpl_ur | output | 1 | Unsupported Request completion for a blocked read |
| cpl_in_valid | input | 1 | Completion from primary valid |
| cpl_in_ready | output | 1 | Completion from primary ready |
| cpl_in_tag | input | TAG_W | Completion tag from primary |
| cpl_out_valid | output | 1 | Completion to secondary valid |
| cpl_out_ready | input | 1 | Completion to secondary ready |
| cpl_out_tag | output | TAG_W | Completion tag to secondary |
| ds_kind | input | 3 | Downstream request kind |
| ds_addr | input | ADDR_W | Downstream request address |
| ds_hit | output | 3 | Window claims: bit 0 I/O, 1 memory, 2 prefetchable |

## Verification
The bench drives addresses exactly at each window's base and limit and one step outside them. A design using strict comparisons would miss the edges, and one with off-by-one bounds would claim neighbours. It programs an empty window and expects silence, which catches a gate that tests only the enable. It checks that interrupt messages have their byte enables cleared like other writes, and that reads keep theirs. It also holds `uo_ready` low to confirm that `cpl_ur` is not raised for a read that was never accepted. A command write is checked to take effect only after its edge, with a request sampled just before.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam int ADDR_W_DEF = 32;
    localparam int BE_W_DEF   = 4;
    localparam int TAG_W_DEF  = 8;
    localparam int CMD_W      = 16;
    localparam int KIND_W     = 3;
    localparam int NUM_WIN    = 3;

    // Bit positions the bridge decodes in the command word
    localparam int CMD_IO_BIT  = 0;
    localparam int CMD_MEM_BIT = 1;
    localparam int CMD_BM_BIT  = 2;

    // Window index into the claim vector
    localparam int WIN_IO   = 0;
    localparam int WIN_MEM  = 1;
    localparam int WIN_PMEM = 2;

    // Legacy redirect target for blocked upstream traffic
    localparam logic [63:0] REDIRECT_ADDR = 64'h0000_0000_000C_0000;

    typedef enum logic [KIND_W-1:0] {
        RQ_MRD  = 3'd0,
        RQ_MWR  = 3'd1,
        RQ_IORD = 3'd2,
        RQ_IOWR = 3'd3,
        RQ_MSI  = 3'd4
    } rq_kind_e;

    typedef struct packed {
        logic bus_master;
        logic mem_space;
        logic io_space;
    } cmd_t;

    function automatic logic kind_is_read(input logic [KIND_W-1:0] k);
        return (k == RQ_MRD) || (k == RQ_IORD);
    endfunction

    function automatic logic kind_is_write(input logic [KIND_W-1:0] k);
        return (k == RQ_MWR) || (k == RQ_IOWR) || (k == RQ_MSI);
    endfunction

    function automatic logic kind_is_mem(input logic [KIND_W-1:0] k);
        return (k == RQ_MRD) || (k == RQ_MWR) || (k == RQ_MSI);
    endfunction

    function automatic logic kind_is_io(input logic [KIND_W-1:0] k);
        return (k == RQ_IORD) || (k == RQ_IOWR);
    endfunction

endpackage

// File: rtl/brg_cmd_reg.sv
module brg_cmd_reg
    import brg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CMD_W-1:0] wdata,
    output logic [CMD_W-1:0] rdata,
    output cmd_t             cmd
);

    cmd_t cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (we) begin
            cmd_q.bus_master <= wdata[CMD_BM_BIT];
            cmd_q.mem_space  <= wdata[CMD_MEM_BIT];
            cmd_q.io_space   <= wdata[CMD_IO_BIT];
        end
    end

    // Upper bits, including the three tied-off features, are not stored
    logic unused_hi_bits;
    assign unused_hi_bits = ^wdata[CMD_W-1:CMD_BM_BIT+1];

    always_comb begin
        rdata              = '0;
        rdata[CMD_BM_BIT]  = cmd_q.bus_master;
        rdata[CMD_MEM_BIT] = cmd_q.mem_space;
        rdata[CMD_IO_BIT]  = cmd_q.io_space;
    end

    assign cmd = cmd_q;

endmodule

// File: rtl/brg_us_gate.sv
module brg_us_gate
    import brg_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int BE_W   = BE_W_DEF
) (
    input  logic              bus_master,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [KIND_W-1:0] in_kind,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BE_W-1:0]   in_be,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [KIND_W-1:0] out_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BE_W-1:0]   out_be,
    output logic              ur_flag
);

    localparam logic [ADDR_W-1:0] LEGACY = ADDR_W'(REDIRECT_ADDR);

    logic blocked;
    logic accepted;

    assign blocked   = !bus_master;
    assign accepted  = in_valid && out_ready;

    assign out_valid = in_valid;
    assign in_ready  = out_ready;
    assign out_kind  = in_kind;

    always_comb begin
        out_addr = in_addr;
        out_be   = in_be;
        if (blocked) begin
            out_addr = LEGACY;
            if (kind_is_write(in_kind)) begin
                out_be = '0;
            end
        end
    end

    assign ur_flag = accepted && blocked && kind_is_read(in_kind);

endmodule

// File: rtl/brg_window.sv
module brg_window #(
    parameter int ADDR_W = 32
) (
    input  logic              enable,
    input  logic              kind_match,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic above_base;
    logic below_limit;

    assign above_base  = (addr >= base);
    assign below_limit = (addr <= limit);

    // An empty window (limit < base) can never satisfy both bounds
    assign hit = enable && kind_match && above_base && below_limit;

endmodule

// File: rtl/bridge_req_gate.sv
module bridge_req_gate
    import brg_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int BE_W   = BE_W_DEF,
    parameter int TAG_W  = TAG_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CMD_W-1:0]  cfg_wdata,
    output logic [CMD_W-1:0]  cfg_rdata,
    input  logic [ADDR_W-1:0] mem_base,
    input  logic [ADDR_W-1:0] mem_limit,
    input  logic [ADDR_W-1:0] pmem_base,
    input  logic [ADDR_W-1:0] pmem_limit,
    input  logic [ADDR_W-1:0] io_base,
    input  logic [ADDR_W-1:0] io_limit,
    input  logic              us_valid,
    output logic              us_ready,
    input  logic [KIND_W-1:0] us_kind,
    input  logic [ADDR_W-1:0] us_addr,
    input  logic [BE_W-1:0]   us_be,
    output logic              uo_valid,
    input  logic              uo_ready,
    output logic [KIND_W-1:0] uo_kind,
    output logic [ADDR_W-1:0] uo_addr,
    output logic [BE_W-1:0]   uo_be,
    output logic              cpl_ur,
    input  logic              cpl_in_valid,
    output logic              cpl_in_ready,
    input  logic [TAG_W-1:0]  cpl_in_tag,
    output logic              cpl_out_valid,
    input  logic              cpl_out_ready,
    output logic [TAG_W-1:0]  cpl_out_tag,
    input  logic [KIND_W-1:0] ds_kind,
    input  logic [ADDR_W-1:0] ds_addr,
    output logic [NUM_WIN-1:0] ds_hit
);

    cmd_t cmd;

    brg_cmd_reg u_cmd (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cmd   (cmd)
    );

    brg_us_gate #(
        .ADDR_W (ADDR_W),
        .BE_W   (BE_W)
    ) u_gate (
        .bus_master (cmd.bus_master),
        .in_valid   (us_valid),
        .in_ready   (us_ready),
        .in_kind    (us_kind),
        .in_addr    (us_addr),
        .in_be      (us_be),
        .out_valid  (uo_valid),
        .out_ready  (uo_ready),
        .out_kind   (uo_kind),
        .out_addr   (uo_addr),
        .out_be     (uo_be),
        .ur_flag    (cpl_ur)
    );

    // Completions toward the secondary side ignore the command word
    assign cpl_out_valid = cpl_in_valid;
    assign cpl_in_ready  = cpl_out_ready;
    assign cpl_out_tag   = cpl_in_tag;

    // Window table, indexed by WIN_* constants
    logic [NUM_WIN-1:0][ADDR_W-1:0] win_base;
    logic [NUM_WIN-1:0][ADDR_W-1:0] win_limit;
    logic [NUM_WIN-1:0]             win_en;
    logic [NUM_WIN-1:0]             win_kind_ok;

    always_comb begin
        win_base[WIN_IO]     = io_base;
        win_limit[WIN_IO]    = io_limit;
        win_en[WIN_IO]       = cmd.io_space;
        win_kind_ok[WIN_IO]  = kind_is_io(ds_kind);
        win_base[WIN_MEM]    = mem_base;
        win_limit[WIN_MEM]   = mem_limit;
        win_en[WIN_MEM]      = cmd.mem_space;
        win_kind_ok[WIN_MEM] = kind_is_mem(ds_kind);
        win_base[WIN_PMEM]   = pmem_base;
        win_limit[WIN_PMEM]  = pmem_limit;
        win_en[WIN_PMEM]     = cmd.mem_space;
        win_kind_ok[WIN_PMEM]= kind_is_mem(ds_kind);
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        brg_window #(
            .ADDR_W (ADDR_W)
        ) u_win (
            .enable     (win_en[w]),
            .kind_match (win_kind_ok[w]),
            .base       (win_base[w]),
            .limit      (win_limit[w]),
            .addr       (ds_addr),
            .hit        (ds_hit[w])
        );
    end

endmodule

// File: rtl/bridge_req_gate_chk.sv
module bridge_req_gate_chk
    import brg_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int BE_W   = BE_W_DEF,
    parameter int TAG_W  = TAG_W_DEF
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_we,
    input logic [CMD_W-1:0]   cfg_wdata,
    input logic [CMD_W-1:0]   cfg_rdata,
    input logic               us_valid,
    input logic               uo_ready,
    input logic [KIND_W-1:0]  us_kind,
    input logic [ADDR_W-1:0]  us_addr,
    input logic [BE_W-1:0]    us_be,
    input logic [ADDR_W-1:0]  uo_addr,
    input logic [BE_W-1:0]    uo_be,
    input logic               cpl_ur,
    input logic               cpl_in_valid,
    input logic               cpl_out_valid,
    input logic [TAG_W-1:0]   cpl_in_tag,
    input logic [TAG_W-1:0]   cpl_out_tag,
    input logic [NUM_WIN-1:0] ds_hit
);

    localparam logic [ADDR_W-1:0] LEGACY = ADDR_W'(REDIRECT_ADDR);

    a_r1_cmd_write: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_rdata[2:0] == $past(cfg_wdata[2:0])));

    a_r2_ro_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[CMD_W-1:3] == '0);

    a_r3_pass: assert property (@(posedge clk) disable iff (rst)
        (us_valid && cfg_rdata[CMD_BM_BIT]) |->
            (uo_addr == us_addr && uo_be == us_be && !cpl_ur));

    a_r4_write_neutral: assert property (@(posedge clk) disable iff (rst)
        (us_valid && !cfg_rdata[CMD_BM_BIT] && kind_is_write(us_kind)) |->
            (uo_addr == LEGACY && uo_be == '0));

    a_r5_read_ur: assert property (@(posedge clk) disable iff (rst)
        (us_valid && uo_ready && !cfg_rdata[CMD_BM_BIT] && kind_is_read(us_kind)) |->
            (cpl_ur && uo_addr == LEGACY));

    a_r5_no_ur_unaccepted: assert property (@(posedge clk) disable iff (rst)
        !(us_valid && uo_ready) |-> !cpl_ur);

    a_r7_cpl_pass: assert property (@(posedge clk) disable iff (rst)
        (cpl_out_valid == cpl_in_valid) && (cpl_out_tag == cpl_in_tag));

    a_r8_mem_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[CMD_MEM_BIT] |-> (ds_hit[WIN_PMEM:WIN_MEM] == 2'b00));

    a_r9_io_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[CMD_IO_BIT] |-> !ds_hit[WIN_IO]);

endmodule

bind bridge_req_gate bridge_req_gate_chk #(
    .ADDR_W (ADDR_W),
    .BE_W   (BE_W),
    .TAG_W  (TAG_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .us_valid      (us_valid),
    .uo_ready      (uo_ready),
    .us_kind       (us_kind),
    .us_addr       (us_addr),
    .us_be         (us_be),
    .uo_addr       (uo_addr),
    .uo_be         (uo_be),
    .cpl_ur        (cpl_ur),
    .cpl_in_valid  (cpl_in_valid),
    .cpl_out_valid (cpl_out_valid),
    .cpl_in_tag    (cpl_in_tag),
    .cpl_out_tag   (cpl_out_tag),
    .ds_hit        (ds_hit)
);

// File: tb/bridge_req_gate_bench.sv
`timescale 1ns/1ps
module bridge_req_gate_bench;

    localparam int AW = 32;
    localparam int BW = 4;
    localparam int TW = 8;
    localparam logic [AW-1:0] LEG = 32'h000C_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic [AW-1:0] mem_base   = 32'h1000_0000;
    logic [AW-1:0] mem_limit  = 32'h1FFF_FFFF;
    logic [AW-1:0] pmem_base  = 32'h4000_0000;
    logic [AW-1:0] pmem_limit = 32'h4FFF_FFFF;
    logic [AW-1:0] io_base    = 32'h0000_1000;
    logic [AW-1:0] io_limit   = 32'h0000_1FFF;
    logic          us_valid = 1'b0;
    logic          us_ready;
    logic [2:0]    us_kind = '0;
    logic [AW-1:0] us_addr = '0;
    logic [BW-1:0] us_be = '0;
    logic          uo_valid;
    logic          uo_ready = 1'b1;
    logic [2:0]    uo_kind;
    logic [AW-1:0] uo_addr;
    logic [BW-1:0] uo_be;
    logic          cpl_ur;
    logic          cpl_in_valid = 1'b0;
    logic          cpl_in_ready;
    logic [TW-1:0] cpl_in_tag = '0;
    logic          cpl_out_valid;
    logic          cpl_out_ready = 1'b0;
    logic [TW-1:0] cpl_out_tag;
    logic [2:0]    ds_kind = '0;
    logic [AW-1:0] ds_addr = '0;
    logic [2:0]    ds_hit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bridge_req_gate u_bridge_req_gate (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_base(mem_base), .mem_limit(mem_limit), .pmem_base(pmem_base), .pmem_limit(pmem_limit),
        .io_base(io_base), .io_limit(io_limit),
        .us_valid(us_valid), .us_ready(us_ready), .us_kind(us_kind), .us_addr(us_addr), .us_be(us_be),
        .uo_valid(uo_valid), .uo_ready(uo_ready), .uo_kind(uo_kind), .uo_addr(uo_addr), .uo_be(uo_be),
        .cpl_ur(cpl_ur), .cpl_in_valid(cpl_in_valid), .cpl_in_ready(cpl_in_ready), .cpl_in_tag(cpl_in_tag),
        .cpl_out_valid(cpl_out_valid), .cpl_out_ready(cpl_out_ready), .cpl_out_tag(cpl_out_tag),
        .ds_kind(ds_kind), .ds_addr(ds_addr), .ds_hit(ds_hit)
    );

    typedef struct packed {
        logic          bm;
        logic [2:0]    kind;
        logic [AW-1:0] addr;
        logic [BW-1:0] be;
        logic [AW-1:0] exp_addr;
        logic [BW-1:0] exp_be;
        logic          exp_ur;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 32'h1000_0040, 4'hF, 32'h1000_0040, 4'hF, 1'b0},
        '{1'b1, 3'd1, 32'h2000_0000, 4'h3, 32'h2000_0000, 4'h3, 1'b0},
        '{1'b1, 3'd3, 32'h0000_1234, 4'h1, 32'h0000_1234, 4'h1, 1'b0},
        '{1'b1, 3'd4, 32'hFEE0_0000, 4'hF, 32'hFEE0_0000, 4'hF, 1'b0},
        '{1'b0, 3'd1, 32'h1000_0040, 4'hF, 32'h000C_0000, 4'h0, 1'b0},
        '{1'b0, 3'd0, 32'h1234_5678, 4'hF, 32'h000C_0000, 4'hF, 1'b1},
        '{1'b0, 3'd2, 32'h0000_1234, 4'h2, 32'h000C_0000, 4'h2, 1'b1},
        '{1'b0, 3'd4, 32'hFEE0_0000, 4'hF, 32'h000C_0000, 4'h0, 1'b0},
        '{1'b0, 3'd3, 32'h0000_0080, 4'h1, 32'h000C_0000, 4'h0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cmd(input logic [15:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic ds_probe(input logic [2:0] k, input logic [AW-1:0] a, input logic [2:0] exp, input string req);
        @(negedge clk);
        ds_kind = k;
        ds_addr = a;
        #1;
        check(ds_hit == exp, req, 64'(ds_hit), 64'(exp));
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset value
        check(cfg_rdata == 16'h0000, "R1 reset", 64'(cfg_rdata), 64'h0);

        // Vector table walk (R3, R4, R5, R6)
        for (int i = 0; i < NV; i++) begin
            write_cmd({13'd0, VECS[i].bm, 2'b00});
            us_valid = 1'b1;
            us_kind  = VECS[i].kind;
            us_addr  = VECS[i].addr;
            us_be    = VECS[i].be;
            #1;
            check(uo_addr == VECS[i].exp_addr, "R3/R4/R5 addr", 64'(uo_addr), 64'(VECS[i].exp_addr));
            check(uo_be == VECS[i].exp_be, "R3/R4/R5 be", 64'(uo_be), 64'(VECS[i].exp_be));
            check(cpl_ur == VECS[i].exp_ur, "R3/R5 ur", 64'(cpl_ur), 64'(VECS[i].exp_ur));
            check(uo_kind == VECS[i].kind, "R4 kind", 64'(uo_kind), 64'(VECS[i].kind));
            check(uo_valid && us_ready, "R6 same beat", 64'({uo_valid, us_ready}), 64'h3);
            @(negedge clk);
            us_valid = 1'b0;
        end

        // R2: all high bits written, only low three read back
        write_cmd(16'hFFFF);
        check(cfg_rdata == 16'h0007, "R2 high bits", 64'(cfg_rdata), 64'h7);
        write_cmd(16'h0038);
        check(cfg_rdata == 16'h0000, "R2 tied-off bits", 64'(cfg_rdata), 64'h0);

        // R5/R6: blocked read with back-pressure is not accepted, no UR
        @(negedge clk);
        uo_ready = 1'b0;
        us_valid = 1'b1;
        us_kind  = 3'd0;
        us_addr  = 32'h1000_0000;
        us_be    = 4'hF;
        #1;
        check(!us_ready, "R6 ready follows", 64'(us_ready), 64'h0);
        check(!cpl_ur, "R5 ur only on accept", 64'(cpl_ur), 64'h0);
        check(uo_addr == LEG, "R5 redirect held", 64'(uo_addr), 64'(LEG));
        uo_ready = 1'b1;
        #1;
        check(cpl_ur, "R5 ur on accept", 64'(cpl_ur), 64'h1);

        // R1 timing: write bus master; before the edge the old value applies
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = 16'h0004;
        us_kind   = 3'd1;
        us_addr   = 32'h1000_0010;
        #1;
        check(uo_addr == LEG, "R1 old value before edge", 64'(uo_addr), 64'(LEG));
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check(uo_addr == 32'h1000_0010, "R1 new value after edge", 64'(uo_addr), 64'h1000_0010);
        us_valid = 1'b0;

        // R7: completions pass while bus master clear
        write_cmd(16'h0000);
        cpl_in_valid  = 1'b1;
        cpl_in_tag    = 8'hA5;
        cpl_out_ready = 1'b1;
        #1;
        check(cpl_out_valid && cpl_in_ready && cpl_out_tag == 8'hA5, "R7 completion pass",
              64'({cpl_out_valid, cpl_in_ready, cpl_out_tag}), 64'h3A5);
        cpl_in_valid = 1'b0;

        // R8/R9: enables clear -> no claims
        ds_probe(3'd0, 32'h1000_0000, 3'b000, "R8 mem disabled");
        ds_probe(3'd2, 32'h0000_1000, 3'b000, "R9 io disabled");

        // R8: memory space on
        write_cmd(16'h0002);
        ds_probe(3'd0, 32'h1000_0000, 3'b010, "R8 mem base");
        ds_probe(3'd1, 32'h1FFF_FFFF, 3'b010, "R8 mem limit");
        ds_probe(3'd1, 32'h2000_0000, 3'b000, "R8 mem limit+1");
        ds_probe(3'd0, 32'h0FFF_FFFF, 3'b000, "R8 mem base-1");
        ds_probe(3'd4, 32'h4FFF_FFFF, 3'b100, "R8 pmem limit");
        ds_probe(3'd0, 32'h4000_0000, 3'b100, "R8 pmem base");
        ds_probe(3'd2, 32'h0000_1000, 3'b000, "R9 io off while mem on");
        ds_probe(3'd2, 32'h1000_0000, 3'b000, "R8 io kind ignores mem window");

        // R9: io space on
        write_cmd(16'h0001);
        ds_probe(3'd2, 32'h0000_1000, 3'b001, "R9 io base");
        ds_probe(3'd3, 32'h0000_1FFF, 3'b001, "R9 io limit");
        ds_probe(3'd3, 32'h0000_2000, 3'b000, "R9 io limit+1");
        ds_probe(3'd0, 32'h0000_1000, 3'b000, "R9 mem kind ignores io window");
        ds_probe(3'd0, 32'h1000_0000, 3'b000, "R8 mem off while io on");

        // R10: empty prefetchable window never claims
        write_cmd(16'h0003);
        @(negedge clk);
        pmem_base  = 32'h5000_0000;
        pmem_limit = 32'h4000_0000;
        ds_probe(3'd0, 32'h5000_0000, 3'b000, "R10 empty at base");
        ds_probe(3'd0, 32'h4000_0000, 3'b000, "R10 empty at limit");
        ds_probe(3'd0, 32'h1000_0000, 3'b010, "R10 other window unaffected");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule